// File: doc/BRIEF.md
# Multi-level address translation walker

This block turns a 64-bit virtual address into an absolute address. It walks a hierarchy of up to four region and segment tables and then a page table, reading one 64-bit table entry at a time through a simple memory read port. A request carries the virtual address, a 64-bit address-space control word, a write flag and two enables for large-frame support. The result comes back on a one-cycle `done` pulse. The pulse carries the translated address or an encoded exception, plus the accumulated protection indication.

The control word selects the level the walk starts at. It also supplies the origin of that first table and a 2-bit length limit. The virtual address splits, from the most significant bit down, into four 11-bit indexes (region-first, region-second, region-third, segment), an 8-bit page index and a 12-bit byte index. Control word fields use LSB-0 numbering:

| Field | Bits |
|---|---|
| origin | 63:12 |
| private | 8 |
| real-space | 5 |
| designation type | 3:2 |
| length | 1:0 |

The designation type values are 0 segment, 1 region-third, 2 region-second and 3 region-first. Prefix relocation is treated as identity. There is no translation caching.

The controller has four states:

- `ST_IDLE` waits for a request and accepts it.
- `ST_ISSUE` holds a table read on the memory port until it is accepted.
- `ST_WAIT` waits for the read data.
- `ST_DONE` presents the result for one cycle.

The transitions are:

- `ST_IDLE`→`ST_DONE` on acceptance when the real-space bit is set or the start-level checks fail.
- `ST_IDLE`→`ST_ISSUE` on acceptance otherwise.
- `ST_ISSUE`→`ST_WAIT` when the read is accepted.
- `ST_WAIT`→`ST_ISSUE` when an entry leads to a further table.
- `ST_WAIT`→`ST_DONE` on a memory error, an entry exception or a final entry.
- `ST_DONE`→`ST_IDLE` always.

Top module: `dat_walker`

## Requirements
- R1: With control word bit 5 set, no table is read: `done` rises the cycle after acceptance with code 0 and `xlat_addr` equal to the virtual address.
- R2: At the start level, a nonzero index of any higher level gives code 6 and no table read. Otherwise, if the top 2 bits of the start index exceed control bits 1:0, the code is that level's translation code (region-first 1, region-second 2, region-third 3, segment 4), again with no read.
- R3: The first read is at origin×4096 + start index×8. A region entry leads to its bits 63:12 ×4096 + next index×8. A segment entry leads to its bits 63:11 ×2048 + page index×8. Every read address is 8-byte aligned.
- R4: An entry whose invalid bit is set (bit 5 in region and segment entries, bit 10 in page entries) ends the walk with that level's translation code (1 to 4 as in R2, page 5).
- R5: A region or segment entry whose bits 3:2 differ from the expected level value (region-first 3, region-second 2, region-third 1, segment 0) ends the walk with code 7.
- R6: In region entries, the top 2 bits of the next index must lie between bits 7:6 and bits 1:0 inclusive. Otherwise the walk ends with the next level's translation code.
- R7: A region-third entry with bit 10 set, while `big_reg_en` is on, ends the walk with address {entry[63:31], va[30:0]}. A segment entry with bit 10 set, while `big_seg_en` is on, ends it with {entry[63:20], va[19:0]}.
- R8: A page entry yields {entry[63:12], va[11:0]}. Its bit 11 set, or its bit 8 set while `big_seg_en` is off, gives code 7.
- R9: With control bit 8 set, a segment entry with bit 4 set gives code 7. So does a region-third entry with bit 4 set while `big_reg_en` is on.
- R10: Entry bit 9 is ORed into `xlat_prot`. This holds at region levels only while `big_seg_en` is on, and always at the segment, page and large-frame final entries. A write that completes with the flag set reports code 8.
- R11: A read response with `mem_rsp_err` set ends the walk with code 9.
- R12: `req_ready` is high only in the idle state. `done` is a single-cycle pulse. A table read request holds its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 64 | Virtual address |
| req_asce | input | 64 | Address-space control word |
| req_write | input | 1 | Access is a write |
| big_seg_en | input | 1 | First large-frame enable |
| big_reg_en | input | 1 | Second large-frame enable |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | Result pulse |
| xlat_exc | output | 4 | Exception code, 0 none |
| xlat_addr | output | 64 | Translated address |
| xlat_prot | output | 1 | Accumulated protection flag |

## Verification
A real-space request and a start-level exception both produce `done` one cycle after acceptance. Every other outcome appears one cycle after the read response that decides it. The bench therefore waits for `done` at falling edges and samples the result there. It also confirms that the next falling edge shows `done` low and the walker idle again. The sequence of table addresses the walker requests is compared against the sequence that a bench model of the walk fetches. This comparison counts each level's reads regardless of the random ready and response delays.

// File: rtl/dat_pkg.sv
package dat_pkg;
    localparam int AW     = 64;
    localparam int IDX_W  = 11;
    localparam int N_IDX  = 4;
    localparam int PX_W   = 8;
    localparam int BX_W   = 12;
    localparam int PG_SH  = 12;
    localparam int PT_SH  = 11;
    localparam int ENT_SH = 3;
    localparam int RFR_LO = AW - 33;
    localparam int SFR_LO = AW - 44;

    typedef enum logic [3:0] {
        EXC_NONE      = 4'd0,
        EXC_R1_TRANS  = 4'd1,
        EXC_R2_TRANS  = 4'd2,
        EXC_R3_TRANS  = 4'd3,
        EXC_SEG_TRANS = 4'd4,
        EXC_PG_TRANS  = 4'd5,
        EXC_TYPE      = 4'd6,
        EXC_SPEC      = 4'd7,
        EXC_PROT      = 4'd8,
        EXC_MEM_FAULT = 4'd9
    } exc_e;

    typedef enum logic [2:0] {
        LV_R1   = 3'd0,
        LV_R2   = 3'd1,
        LV_R3   = 3'd2,
        LV_SEG  = 3'd3,
        LV_PAGE = 3'd4
    } level_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } state_e;

    function automatic logic [IDX_W-1:0] idx_of(input logic [AW-1:0] va, input int k);
        return va[AW-1-IDX_W*k -: IDX_W];
    endfunction

    function automatic exc_e trans_exc(input level_e l);
        return exc_e'({1'b0, l} + 4'd1);
    endfunction
endpackage

// File: rtl/dat_start_check.sv
module dat_start_check
    import dat_pkg::*;
(
    input  logic [AW-1:0] va,
    input  logic [AW-1:0] asce,
    output level_e        lvl,
    output exc_e          exc,
    output logic [AW-1:0] ptr
);
    logic [IDX_W-1:0] sidx;
    logic             hi_nz;
    logic             unused_bits;

    assign unused_bits = ^{asce[11:4]};

    always_comb begin
        lvl   = level_e'(3'd3 - {1'b0, asce[3:2]});
        sidx  = idx_of(va, int'(lvl));
        hi_nz = 1'b0;
        for (int k = 0; k < N_IDX - 1; k++) begin
            if (k < int'(lvl) && idx_of(va, k) != '0) hi_nz = 1'b1;
        end
        if (hi_nz)
            exc = EXC_TYPE;
        else if (sidx[IDX_W-1 -: 2] > asce[1:0])
            exc = trans_exc(lvl);
        else
            exc = EXC_NONE;
        ptr = {asce[AW-1:PG_SH], {PG_SH{1'b0}}} + AW'({sidx, {ENT_SH{1'b0}}});
    end
endmodule

// File: rtl/dat_entry_eval.sv
module dat_entry_eval
    import dat_pkg::*;
(
    input  level_e        lvl,
    input  logic [AW-1:0] entry,
    input  logic [AW-1:0] va,
    input  logic          priv,
    input  logic          en1,
    input  logic          en2,
    output exc_e          exc,
    output logic          last,
    output logic [AW-1:0] next,
    output logic          prot_hit
);
    logic [IDX_W-1:0] nidx;
    logic [1:0]       ntop;

    always_comb begin
        exc      = EXC_NONE;
        last     = 1'b0;
        next     = '0;
        prot_hit = 1'b0;
        nidx     = '0;
        ntop     = '0;
        unique case (lvl)
            LV_R1, LV_R2, LV_R3: begin
                nidx = idx_of(va, int'(lvl) + 1);
                ntop = nidx[IDX_W-1 -: 2];
                if (entry[5])
                    exc = trans_exc(lvl);
                else if (entry[3:2] != 2'(3'd3 - lvl))
                    exc = EXC_SPEC;
                else if (lvl == LV_R3 && en2 && entry[4] && priv)
                    exc = EXC_SPEC;
                else if (lvl == LV_R3 && en2 && entry[10]) begin
                    last     = 1'b1;
                    prot_hit = entry[9];
                    next     = {entry[AW-1:RFR_LO], va[RFR_LO-1:0]};
                end else if (ntop < entry[7:6] || ntop > entry[1:0])
                    exc = trans_exc(level_e'(lvl + 3'd1));
                else begin
                    prot_hit = en1 & entry[9];
                    next = {entry[AW-1:PG_SH], {PG_SH{1'b0}}} + AW'({nidx, {ENT_SH{1'b0}}});
                end
            end
            LV_SEG: begin
                if (entry[5])
                    exc = EXC_SEG_TRANS;
                else if (entry[3:2] != 2'd0)
                    exc = EXC_SPEC;
                else if (entry[4] && priv)
                    exc = EXC_SPEC;
                else if (entry[10] && en1) begin
                    last     = 1'b1;
                    prot_hit = entry[9];
                    next     = {entry[AW-1:SFR_LO], va[SFR_LO-1:0]};
                end else begin
                    prot_hit = entry[9];
                    next = {entry[AW-1:PT_SH], {PT_SH{1'b0}}}
                         + AW'({va[PG_SH+PX_W-1:PG_SH], {ENT_SH{1'b0}}});
                end
            end
            LV_PAGE: begin
                if (entry[10])
                    exc = EXC_PG_TRANS;
                else if (entry[11] || (entry[8] && !en1))
                    exc = EXC_SPEC;
                else begin
                    last     = 1'b1;
                    prot_hit = entry[9];
                    next     = {entry[AW-1:BX_W], va[BX_W-1:0]};
                end
            end
            default: exc = EXC_SPEC;
        endcase
    end
endmodule

// File: rtl/dat_walker.sv
module dat_walker
    import dat_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [63:0]   req_va,
    input  logic [63:0]   req_asce,
    input  logic          req_write,
    input  logic          big_seg_en,
    input  logic          big_reg_en,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [63:0]   mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [63:0]   mem_rsp_data,
    input  logic          mem_rsp_err,
    output logic          done,
    output logic [3:0]    xlat_exc,
    output logic [63:0]   xlat_addr,
    output logic          xlat_prot
);
    state_e        state, state_nx;
    level_e        lvl_q;
    logic [AW-1:0] ptr_q, va_q, addr_q;
    logic          priv_q, wr_q, en1_q, en2_q, prot_q;
    exc_e          exc_q;

    level_e        st_lvl;
    exc_e          st_exc;
    logic [AW-1:0] st_ptr;
    exc_e          ev_exc;
    logic          ev_last, ev_prot;
    logic [AW-1:0] ev_next;

    logic accept, real_sp, rsp_end;

    dat_start_check u_start (
        .va   (req_va),
        .asce (req_asce),
        .lvl  (st_lvl),
        .exc  (st_exc),
        .ptr  (st_ptr)
    );

    dat_entry_eval u_eval (
        .lvl      (lvl_q),
        .entry    (mem_rsp_data),
        .va       (va_q),
        .priv     (priv_q),
        .en1      (en1_q),
        .en2      (en2_q),
        .exc      (ev_exc),
        .last     (ev_last),
        .next     (ev_next),
        .prot_hit (ev_prot)
    );

    assign accept  = (state == ST_IDLE) && req_valid;
    assign real_sp = req_asce[5];
    assign rsp_end = mem_rsp_err || (ev_exc != EXC_NONE) || ev_last;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = (real_sp || st_exc != EXC_NONE) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_nx = rsp_end ? ST_DONE : ST_ISSUE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= LV_R1;
            ptr_q  <= '0;
            va_q   <= '0;
            addr_q <= '0;
            priv_q <= 1'b0;
            wr_q   <= 1'b0;
            en1_q  <= 1'b0;
            en2_q  <= 1'b0;
            prot_q <= 1'b0;
            exc_q  <= EXC_NONE;
        end else if (accept) begin
            va_q   <= req_va;
            priv_q <= req_asce[8];
            wr_q   <= req_write;
            en1_q  <= big_seg_en;
            en2_q  <= big_reg_en;
            prot_q <= 1'b0;
            exc_q  <= EXC_NONE;
            addr_q <= '0;
            if (real_sp)
                addr_q <= req_va;
            else if (st_exc != EXC_NONE)
                exc_q <= st_exc;
            else begin
                ptr_q <= st_ptr;
                lvl_q <= st_lvl;
            end
        end else if (state == ST_WAIT && mem_rsp_valid) begin
            if (mem_rsp_err)
                exc_q <= EXC_MEM_FAULT;
            else if (ev_exc != EXC_NONE)
                exc_q <= ev_exc;
            else if (ev_last) begin
                addr_q <= ev_next;
                prot_q <= prot_q | ev_prot;
                exc_q  <= (wr_q && (prot_q || ev_prot)) ? EXC_PROT : EXC_NONE;
            end else begin
                ptr_q  <= ev_next;
                lvl_q  <= level_e'(lvl_q + 3'd1);
                prot_q <= prot_q | ev_prot;
            end
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign done          = (state == ST_DONE);
    assign mem_req_valid = (state == ST_ISSUE);
    assign mem_req_addr  = ptr_q;
    assign xlat_exc      = exc_q;
    assign xlat_addr     = addr_q;
    assign xlat_prot     = prot_q;

    p_real_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_valid && req_asce[5] |=> done && xlat_exc == 4'd0 && xlat_addr == $past(req_va));

    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'd0);

    p_write_prot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && xlat_exc == 4'd0 && wr_q |-> !xlat_prot);

    p_mem_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT && mem_rsp_valid && mem_rsp_err |=> done && xlat_exc == 4'd9);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

// File: tb/tb_dat_walker.sv
module tb_dat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, big_seg_en = 1'b0, big_reg_en = 1'b0;
    logic [63:0] req_va = '0, req_asce = '0;
    logic        req_ready, mem_req_valid, done, xlat_prot;
    logic        mem_req_ready, mem_rsp_valid, mem_rsp_err;
    logic [63:0] mem_req_addr, mem_rsp_data, xlat_addr;
    logic [3:0]  xlat_exc;

    int total = 0, bad = 0;
    logic [63:0] mem [logic [63:0]];
    bit          errm [logic [63:0]];
    logic [63:0] exp_q[$], act_q[$];

    always #5 clk = ~clk;

    dat_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_asce(req_asce), .req_write(req_write),
        .big_seg_en(big_seg_en), .big_reg_en(big_reg_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done(done), .xlat_exc(xlat_exc), .xlat_addr(xlat_addr), .xlat_prot(xlat_prot)
    );

    task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
        end
    endtask

    function automatic logic [10:0] vidx(input logic [63:0] va, input int k);
        return va[63-11*k -: 11];
    endfunction

    function automatic logic [63:0] mkva(input logic [10:0] a, b, c, d, input logic [7:0] px, input logic [11:0] bx);
        return {a, b, c, d, px, bx};
    endfunction

    function automatic logic [63:0] mk_asce(input logic [51:0] pg, input logic [1:0] dt, tl, input logic priv);
        return {pg, 12'h0} | (64'(priv) << 8) | (64'(dt) << 2) | 64'(tl);
    endfunction

    function automatic logic [63:0] gen_entry(input int lv);
        logic [63:0] e;
        e = {$urandom, $urandom};
        if (lv < 4) begin
            e[3:2] = ($urandom % 16 == 0) ? 2'($urandom) : 2'(3 - lv);
            e[5]   = ($urandom % 20 == 0);
            e[4]   = ($urandom % 8 == 0);
            e[10]  = ($urandom % 3 == 0);
            e[7:6] = ($urandom % 8 == 0) ? 2'($urandom) : 2'd0;
            e[1:0] = ($urandom % 8 == 0) ? 2'($urandom) : 2'd3;
        end else begin
            e[10] = ($urandom % 20 == 0);
            e[11] = ($urandom % 20 == 0);
            e[8]  = ($urandom % 8 == 0);
        end
        e[9] = ($urandom % 4 == 0);
        return e;
    endfunction

    function automatic logic [63:0] fetch(input logic [63:0] a, input int lv);
        if (!mem.exists(a)) begin
            mem[a] = gen_entry(lv);
            if ($urandom % 40 == 0) errm[a] = 1'b1;
        end
        return mem[a];
    endfunction

    // Independent walk model built from R1..R11
    task automatic model(input logic [63:0] va, asce, input logic wr, e1, e2,
                         output logic [3:0] ee, output logic [63:0] ea, output logic ep);
        int lv;
        logic [63:0] p, e;
        logic [10:0] t;
        logic [1:0] n;
        bit fin;
        ee = 0; ea = 0; ep = 0; fin = 0;
        if (asce[5]) begin ea = va; return; end
        lv = 3 - int'(asce[3:2]);
        for (int k = 0; k < lv; k++) if (vidx(va, k) != 0) begin ee = 6; return; end
        t = vidx(va, lv);
        if (t[10:9] > asce[1:0]) begin ee = 4'(lv + 1); return; end
        p = {asce[63:12], 12'h0} + 64'(t) * 8;
        while (!fin) begin
            e = fetch(p, lv);
            exp_q.push_back(p);
            if (errm.exists(p)) begin ee = 9; return; end
            if (lv < 3) begin
                if (e[5]) begin ee = 4'(lv + 1); return; end
                if (e[3:2] != 2'(3 - lv)) begin ee = 7; return; end
                if (lv == 2 && e2 && e[4] && asce[8]) begin ee = 7; return; end
                if (lv == 2 && e2 && e[10]) begin
                    ep |= e[9]; ea = {e[63:31], va[30:0]}; fin = 1;
                end else begin
                    t = vidx(va, lv + 1);
                    n = t[10:9];
                    if (n < e[7:6] || n > e[1:0]) begin ee = 4'(lv + 2); return; end
                    if (e1) ep |= e[9];
                    p = {e[63:12], 12'h0} + 64'(t) * 8;
                    lv++;
                end
            end else if (lv == 3) begin
                if (e[5]) begin ee = 4; return; end
                if (e[3:2] != 2'd0) begin ee = 7; return; end
                if (e[4] && asce[8]) begin ee = 7; return; end
                if (e[10] && e1) begin
                    ep |= e[9]; ea = {e[63:20], va[19:0]}; fin = 1;
                end else begin
                    ep |= e[9];
                    p = {e[63:11], 11'h0} + 64'(va[19:12]) * 8;
                    lv = 4;
                end
            end else begin
                if (e[10]) begin ee = 5; return; end
                if (e[11] || (e[8] && !e1)) begin ee = 7; return; end
                ep |= e[9]; ea = {e[63:12], va[11:0]}; fin = 1;
            end
        end
        if (wr && ep) ee = 8;
    endtask

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0: return "R8";
            4'd6: return "R2";
            4'd7: return "R5";
            4'd8: return "R10";
            4'd9: return "R11";
            default: return "R4";
        endcase
    endfunction

    task automatic run(input logic [63:0] va, asce, input logic wr, e1, e2, input string tag);
        logic [3:0] ee;
        logic [63:0] ea;
        logic ep;
        string t;
        int cyc;
        bit same;
        exp_q.delete();
        act_q.delete();
        model(va, asce, wr, e1, e2, ee, ea, ep);
        t = (tag == "") ? req_of(ee) : tag;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_asce = asce; req_write = wr;
        big_seg_en = e1; big_reg_en = e2;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        chk("R12", "done seen", 64'(done), 64'd1);
        chk(t, "exception code", 64'(xlat_exc), 64'(ee));
        if (ee == 0) chk(t, "address", xlat_addr, ea);
        if (ee == 0 || ee == 8) chk("R10", "protection flag", 64'(xlat_prot), 64'(ep));
        same = (act_q.size() == exp_q.size());
        if (same) foreach (exp_q[i]) if (act_q[i] !== exp_q[i]) same = 0;
        chk("R3", "read sequence", 64'(act_q.size()), same ? 64'(act_q.size()) : 64'(exp_q.size()) + 64'd1000);
        if (asce[5]) chk("R1", "bypass latency", 64'(cyc), 64'd1);
        @(negedge clk);
        chk("R12", "done pulse ends", {62'd0, done, req_ready}, 64'd1);
    endtask

    task automatic put(input logic [63:0] a, input logic [63:0] d);
        mem[a] = d;
    endtask

    task automatic clr;
        mem.delete();
        errm.delete();
    endtask

    // memory responder
    initial begin
        logic [63:0] pa;
        bit pend;
        int dly;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
        pend = 0; dly = 0; pa = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err = 1'b0;
            if (pend && dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem.exists(pa) ? mem[pa] : 64'd0;
                mem_rsp_err = errm.exists(pa);
                pend = 0;
            end else if (pend) dly--;
            mem_req_ready = ($urandom % 4 != 0);
            if (mem_req_valid && mem_req_ready && !pend) begin
                pa = mem_req_addr;
                act_q.push_back(pa);
                pend = 1;
                dly = $urandom % 3;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R12 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] va, asce;
        int st;
        logic e1;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "reset idle", {61'd0, req_ready, done, mem_req_valid}, 64'd4);

        // R1 real-space bypass
        clr();
        run(64'h1234_5678_9ABC_DEF0, 64'h20 | mk_asce(52'h5, 2'd3, 2'd0, 1'b0), 1'b1, 1'b1, 1'b1, "R1");
        // R2 higher index nonzero, and start index over length
        run(mkva(0, 11'd1, 0, 0, 0, 0), mk_asce(52'h100, 2'd1, 2'd3, 1'b0), 1'b0, 1'b0, 1'b0, "R2");
        run(mkva(0, 0, 0, 11'h200, 0, 0), mk_asce(52'h100, 2'd0, 2'd0, 1'b0), 1'b0, 1'b0, 1'b0, "R2");
        // R3 R8 R10 segment-start walk to a page
        clr();
        put(64'h10028, 64'h20000);
        put(64'h20108, 64'h0000_00AB_CDEF_0200);
        run(mkva(0, 0, 0, 11'd5, 8'h21, 12'hABC), mk_asce(52'h10, 2'd0, 2'd3, 1'b0), 1'b0, 1'b0, 1'b0, "R8");
        run(mkva(0, 0, 0, 11'd5, 8'h21, 12'hABC), mk_asce(52'h10, 2'd0, 2'd3, 1'b0), 1'b1, 1'b0, 1'b0, "R10");
        // R11 error on the page read
        errm[64'h20108] = 1'b1;
        run(mkva(0, 0, 0, 11'd5, 8'h21, 12'hABC), mk_asce(52'h10, 2'd0, 2'd3, 1'b0), 1'b0, 1'b0, 1'b0, "R11");
        // R6 range check on the next index
        clr();
        put(64'h30010, 64'h4008B);
        run(mkva(0, 11'd2, 11'h200, 0, 0, 0), mk_asce(52'h30, 2'd2, 2'd3, 1'b0), 1'b0, 1'b0, 1'b0, "R6");
        // R7 region-third large frame, with and without the second enable
        clr();
        put(64'h50018, 64'hFFFF_FFFF_8000_0604);
        run(mkva(0, 0, 11'd3, 11'h7FF, 8'hFF, 12'h123), mk_asce(52'h50, 2'd1, 2'd3, 1'b0), 1'b0, 1'b1, 1'b1, "R7");
        run(mkva(0, 0, 11'd3, 11'h7FF, 8'hFF, 12'h123), mk_asce(52'h50, 2'd1, 2'd3, 1'b0), 1'b0, 1'b1, 1'b0, "R6");
        // R7 segment large frame
        clr();
        put(64'h60008, 64'h1234_5678_9AB0_0400);
        run(mkva(0, 0, 0, 11'd1, 8'h5A, 12'h777), mk_asce(52'h60, 2'd0, 2'd3, 1'b0), 1'b0, 1'b1, 1'b0, "R7");
        // R9 common segment in a private space
        clr();
        put(64'h70000, 64'h80010);
        run(64'd0, mk_asce(52'h70, 2'd0, 2'd3, 1'b1), 1'b0, 1'b0, 1'b0, "R9");
        // R10 region protection gated by the first enable
        clr();
        put(64'h80000, 64'h90207);
        put(64'h90000, 64'hA0000);
        put(64'hA0000, 64'hB000);
        run(64'd0, mk_asce(52'h80, 2'd1, 2'd3, 1'b0), 1'b1, 1'b0, 1'b0, "R10");
        run(64'd0, mk_asce(52'h80, 2'd1, 2'd3, 1'b0), 1'b1, 1'b1, 1'b0, "R10");
        // R8 zero bit and override bit
        put(64'hA0000, 64'hB800);
        run(64'd0, mk_asce(52'h80, 2'd1, 2'd3, 1'b0), 1'b0, 1'b1, 1'b0, "R8");
        put(64'hA0000, 64'hB100);
        run(64'd0, mk_asce(52'h80, 2'd1, 2'd3, 1'b0), 1'b0, 1'b0, 1'b0, "R8");
        run(64'd0, mk_asce(52'h80, 2'd1, 2'd3, 1'b0), 1'b0, 1'b1, 1'b0, "R8");
        // R4 invalid page, R5 wrong table type
        put(64'hA0000, 64'hB400);
        run(64'd0, mk_asce(52'h80, 2'd1, 2'd3, 1'b0), 1'b0, 1'b0, 1'b0, "R4");
        put(64'h90000, 64'hA0004);
        run(64'd0, mk_asce(52'h80, 2'd1, 2'd3, 1'b0), 1'b0, 1'b0, 1'b0, "R5");
        put(64'h90000, 64'hA0020);
        run(64'd0, mk_asce(52'h80, 2'd1, 2'd3, 1'b0), 1'b0, 1'b0, 1'b0, "R4");

        // constrained random walks
        for (int n = 0; n < 300; n++) begin
            clr();
            va = {$urandom, $urandom};
            asce = {$urandom, $urandom};
            asce[5] = ($urandom % 12 == 0);
            if ($urandom % 4 != 0) asce[1:0] = 2'd3;
            st = 3 - int'(asce[3:2]);
            for (int k = 0; k < st; k++) if ($urandom % 8 != 0) va[63-11*k -: 11] = '0;
            e1 = ($urandom % 4 != 0);
            run(va, asce, 1'($urandom), e1, e1 & 1'($urandom), "");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule